// File: doc/BRIEF.md
# Pulsed Envelope Ramp Generator

This block produces the amplitude code for an RF attenuator or VGA DAC, one burst at a time. A burst starts when a ramp-up command arrives while the generator is idle. The output then jumps to a low soft-start level and climbs toward the effective target. Each step is bounded by a programmable slope, and a prescaler sets how many clock cycles pass between steps. The output then holds at the target until a ramp-down command walks it back to zero at the same bounded slope.

The effective target is the setpoint captured between bursts. It is clamped to a maximum code, and it is lowered further while the soft-limit derate input is active. While the output holds, it slews toward any new effective target at the bounded slope. The mute input has priority over everything else. It zeroes the output in the same cycle and returns the generator to idle. A one-cycle done pulse marks the end of each ramp, and a ramping flag shows that a ramp is in progress.

Top module: `env_ramp_gen`

## Requirements
- R1: Outside the start of a burst and outside mute, `amp_code` changes by at most `slope` from one cycle to the next. With `slope`=16, `soft_start`=64, a target of 256 and `step_div`=0, the rise from 64 to 256 takes exactly 12 steps, one per cycle.
- R2: A ramp-up command accepted in idle sets `amp_code`, at the next clock edge, to the smaller of `soft_start` and the effective target. If that value equals the target, the generator goes straight to hold and pulses `ramp_done`.
- R3: While `mute` is high, `amp_code` is 0 and `ramp_done` and `ramping` are 0 in that same cycle, whatever the other inputs are. After reset, and after `mute` falls, the generator is idle at code 0 until a new ramp-up command.
- R4: The setpoint is captured only while the generator is idle. Changes to `setpoint` during a burst have no effect on that burst.
- R5: The effective target is the minimum of the captured setpoint, `max_code` and, when `derate_en`=1, `derate_code`. `amp_code` never exceeds `max_code`.
- R6: While the output holds, a change of the effective target (derate applied or removed) makes the output slew toward the new target by `slope` per step.
- R7: `ramp_done` is high for one cycle on the clock edge where a rise reaches the effective target, or where a fall reaches code 0.
- R8: A ramp-up command during a fall reverses the direction. On the command edge the code stays where it is, and later steps rise from that code.
- R9: Steps occur once every `step_div`+1 clock cycles while a burst is active. The code is constant between steps, and the prescaler restarts from zero with each burst.
- R10: When ramp-up and ramp-down arrive in the same cycle, ramp-down wins. A ramp-down command in idle is ignored.
- R11: `ramping` is high during a rise or a fall, and also during hold while the code differs from the effective target. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setpoint | input | CODE_W | Requested target code, captured while idle |
| slope | input | SLOPE_W | Largest code change per step |
| soft_start | input | CODE_W | First code of each burst |
| max_code | input | CODE_W | Upper clamp on the effective target |
| step_div | input | DIV_W | Clock cycles between steps, minus one |
| derate_en | input | 1 | Soft-limit active |
| derate_code | input | CODE_W | Target ceiling while the soft limit is active |
| ramp_up | input | 1 | Start a burst, or reverse a fall |
| ramp_down | input | 1 | Ramp toward zero |
| mute | input | 1 | Override: output zero, return to idle |
| amp_code | output | CODE_W | Attenuator/VGA amplitude code |
| ramp_done | output | 1 | One-cycle pulse at the end of a ramp |
| ramping | output | 1 | A ramp is in progress |

## Verification
Three kinds of internal fault show up at the ports, each within one step interval. A wrong phase state shows as a missed or doubled done pulse, or as a reversal that jumps. A wrong step count shows as a code that moves between steps or by more than the slope. A stale target capture shows as a hold level different from the clamped setpoint. A reference model runs in the bench every cycle, so such a fault is reported on the first cycle the code, the done pulse or the ramping flag leaves its expected value. Directed checks add fixed values at the soft-start, reversal, prescaler, derate and mute points.

// File: rtl/env_ramp_pkg.sv
// Shared types for the envelope ramp generator.
package env_ramp_pkg;

    // Phase of the burst: idle at zero, rising, holding at target, falling.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_HOLD = 2'd2,
        ST_FALL = 2'd3
    } ramp_state_t;

endpackage

// File: rtl/env_step_timer.sv
// Step-interval prescaler. Emits one tick every div+1 cycles while run is
// high and restarts from zero whenever run is low.
// Assumes div may change at any time; a lowered div takes effect at once.
module env_step_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= div);

    // Count cycles between steps; clear when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/env_target_sel.sv
// Effective-target selection. Captures the setpoint while the generator is
// idle, then clamps it to the maximum code and to the derate ceiling.
// Also returns the burst start code, never above the effective target.
// Assumes capture is high exactly while the generator is idle.
module env_target_sel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [CODE_W-1:0] max_code,
    input  logic              derate_en,
    input  logic [CODE_W-1:0] derate_code,
    input  logic [CODE_W-1:0] soft_start,
    output logic [CODE_W-1:0] eff_code,
    output logic [CODE_W-1:0] start_code
);

    logic [CODE_W-1:0] sp_q;
    logic [CODE_W-1:0] raw_code;
    logic [CODE_W-1:0] clamp_code;

    // Hold the setpoint for the duration of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (capture) begin
            sp_q <= setpoint;
        end
    end

    // While idle the live setpoint is used so a burst start sees it at once.
    always_comb begin
        raw_code   = capture ? setpoint : sp_q;
        clamp_code = (raw_code > max_code) ? max_code : raw_code;
        if (derate_en && (clamp_code > derate_code)) begin
            eff_code = derate_code;
        end else begin
            eff_code = clamp_code;
        end
        start_code = (soft_start < eff_code) ? soft_start : eff_code;
    end

endmodule

// File: rtl/env_slew_step.sv
// Combinational slope limiter. Gives the next code one step toward a
// target, and the next code one step toward zero.
// Assumes SLOPE_W <= CODE_W; the sums are computed one bit wider so they
// cannot wrap.
module env_slew_step #(
    parameter int CODE_W  = 12,
    parameter int SLOPE_W = 8
) (
    input  logic [CODE_W-1:0]  cur_code,
    input  logic [CODE_W-1:0]  tgt_code,
    input  logic [SLOPE_W-1:0] slope,
    output logic [CODE_W-1:0]  toward_code,
    output logic [CODE_W-1:0]  fall_code
);

    logic [CODE_W-1:0] slope_ext;
    logic [CODE_W:0]   up_sum;
    logic [CODE_W-1:0] gap_dn;

    assign slope_ext = CODE_W'(slope);
    assign up_sum    = {1'b0, cur_code} + {1'b0, slope_ext};
    assign gap_dn    = cur_code - tgt_code;

    // One bounded step toward the target, landing exactly on it.
    always_comb begin
        if (cur_code < tgt_code) begin
            toward_code = (up_sum > {1'b0, tgt_code}) ? tgt_code : up_sum[CODE_W-1:0];
        end else if (cur_code > tgt_code) begin
            toward_code = (gap_dn > slope_ext) ? (cur_code - slope_ext) : tgt_code;
        end else begin
            toward_code = cur_code;
        end
    end

    // One bounded step toward zero.
    always_comb begin
        fall_code = (cur_code > slope_ext) ? (cur_code - slope_ext) : '0;
    end

endmodule

// File: rtl/env_ramp_gen.sv
// Pulsed envelope ramp generator, top level.
// Sequences each burst through idle, soft start, bounded rise, hold with
// target tracking, and bounded fall. Mute forces code zero combinationally
// and resets the sequence at the next edge. A command edge changes phase
// without moving the code; steps happen only on prescaler ticks.
// Assumes slope >= 1 (a zero slope holds the code) and SLOPE_W <= CODE_W.
module env_ramp_gen
    import env_ramp_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int SLOPE_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  setpoint,
    input  logic [SLOPE_W-1:0] slope,
    input  logic [CODE_W-1:0]  soft_start,
    input  logic [CODE_W-1:0]  max_code,
    input  logic [DIV_W-1:0]   step_div,
    input  logic               derate_en,
    input  logic [CODE_W-1:0]  derate_code,
    input  logic               ramp_up,
    input  logic               ramp_down,
    input  logic               mute,
    output logic [CODE_W-1:0]  amp_code,
    output logic               ramp_done,
    output logic               ramping
);

    ramp_state_t       state_q, state_n;
    logic [CODE_W-1:0] amp_q, amp_n;
    logic              done_q, done_n;
    logic              tick;
    logic              step_run;
    logic              idle;
    logic [CODE_W-1:0] eff_code;
    logic [CODE_W-1:0] start_code;
    logic [CODE_W-1:0] toward_code;
    logic [CODE_W-1:0] fall_code;

    assign idle     = (state_q == ST_IDLE);
    assign step_run = !idle && !mute;

    env_step_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (step_run),
        .div  (step_div),
        .tick (tick)
    );

    env_target_sel #(
        .CODE_W(CODE_W)
    ) u_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (idle),
        .setpoint   (setpoint),
        .max_code   (max_code),
        .derate_en  (derate_en),
        .derate_code(derate_code),
        .soft_start (soft_start),
        .eff_code   (eff_code),
        .start_code (start_code)
    );

    env_slew_step #(
        .CODE_W (CODE_W),
        .SLOPE_W(SLOPE_W)
    ) u_slew (
        .cur_code   (amp_q),
        .tgt_code   (eff_code),
        .slope      (slope),
        .toward_code(toward_code),
        .fall_code  (fall_code)
    );

    // Phase sequencing: mute first, then ramp-down, then ramp-up, then steps.
    always_comb begin
        state_n = state_q;
        amp_n   = amp_q;
        done_n  = 1'b0;
        if (mute) begin
            state_n = ST_IDLE;
            amp_n   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ramp_up && !ramp_down) begin
                        amp_n = start_code;
                        if (start_code == eff_code) begin
                            state_n = ST_HOLD;
                            done_n  = 1'b1;
                        end else begin
                            state_n = ST_RISE;
                        end
                    end
                end
                ST_RISE, ST_HOLD: begin
                    if (ramp_down) begin
                        state_n = ST_FALL;
                    end else if (tick) begin
                        amp_n = toward_code;
                        if ((state_q == ST_RISE) && (toward_code == eff_code)) begin
                            state_n = ST_HOLD;
                            done_n  = 1'b1;
                        end
                    end
                end
                ST_FALL: begin
                    if (ramp_up && !ramp_down) begin
                        state_n = ST_RISE;
                    end else if (tick) begin
                        amp_n = fall_code;
                        if (fall_code == '0) begin
                            state_n = ST_IDLE;
                            done_n  = 1'b1;
                        end
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    amp_n   = '0;
                end
            endcase
        end
    end

    // Phase, code and done-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            amp_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            amp_q   <= amp_n;
            done_q  <= done_n;
        end
    end

    // Outputs: mute gates the code and the flags without waiting for an edge.
    assign amp_code  = mute ? '0 : amp_q;
    assign ramp_done = done_q && !mute;
    assign ramping   = !mute && ((state_q == ST_RISE) || (state_q == ST_FALL) ||
                                 ((state_q == ST_HOLD) && (amp_q != eff_code)));

endmodule

// File: rtl/env_ramp_chk.sv
// Property checker for the envelope ramp generator, bound to the top.
// Keeps one-cycle history of its own so no property reaches before reset.
module env_ramp_chk
    import env_ramp_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int SLOPE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mute,
    input logic               ramp_done,
    input logic [CODE_W-1:0]  amp_q,
    input ramp_state_t        state_q,
    input logic               tick,
    input logic [SLOPE_W-1:0] slope,
    input logic [CODE_W-1:0]  max_code
);

    logic              hist_ok;
    logic [CODE_W-1:0] amp_d1;
    logic [CODE_W-1:0] max_d1;
    logic [SLOPE_W-1:0] slope_d1;
    ramp_state_t       state_d1;
    logic              tick_d1;
    logic              mute_d1;
    logic [CODE_W-1:0] step_mag;

    // One-cycle history of the values that produced the present code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_ok  <= 1'b0;
            amp_d1   <= '0;
            max_d1   <= '0;
            slope_d1 <= '0;
            state_d1 <= ST_IDLE;
            tick_d1  <= 1'b0;
            mute_d1  <= 1'b0;
        end else begin
            hist_ok  <= 1'b1;
            amp_d1   <= amp_q;
            max_d1   <= max_code;
            slope_d1 <= slope;
            state_d1 <= state_q;
            tick_d1  <= tick;
            mute_d1  <= mute;
        end
    end

    assign step_mag = (amp_q >= amp_d1) ? (amp_q - amp_d1) : (amp_d1 - amp_q);

    // R1: code moves by at most the slope outside burst start and mute.
    a_r1_slope_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && (state_d1 != ST_IDLE) && !mute_d1) |-> (step_mag <= CODE_W'(slope_d1)));

    // R3: after a muted cycle the sequence is back at zero with no done pulse.
    a_r3_mute_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> ((amp_q == '0) && !ramp_done));

    // R5: the code stays within the maximum it was produced under.
    a_r5_within_max: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && (amp_d1 <= max_d1)) |-> (amp_q <= max_d1));

    // R7: a rise-end done pulse lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && (state_q == ST_HOLD)) |=> !ramp_done);

    // R8: reversing a fall keeps the code where it was.
    a_r8_reverse_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && (state_d1 == ST_FALL) && (state_q == ST_RISE)) |-> (amp_q == amp_d1));

    // R9: during a burst the code moves only on prescaler ticks.
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && (state_d1 != ST_IDLE) && !tick_d1 && !mute_d1) |-> (amp_q == amp_d1));

endmodule

bind env_ramp_gen env_ramp_chk #(
    .CODE_W (CODE_W),
    .SLOPE_W(SLOPE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mute     (mute),
    .ramp_done(ramp_done),
    .amp_q    (amp_q),
    .state_q  (state_q),
    .tick     (tick),
    .slope    (slope),
    .max_code (max_code)
);

// File: tb/env_ramp_gen_tb.sv
// Bench for the envelope ramp generator: a behavioural per-cycle model
// compared on every clock, plus directed checks with fixed values.
module env_ramp_gen_tb;

    localparam int CODE_W  = 12;
    localparam int SLOPE_W = 8;
    localparam int DIV_W   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CODE_W-1:0]  setpoint = 12'd256;
    logic [SLOPE_W-1:0] slope = 8'd16;
    logic [CODE_W-1:0]  soft_start = 12'd64;
    logic [CODE_W-1:0]  max_code = 12'd4000;
    logic [DIV_W-1:0]   step_div = 8'd0;
    logic               derate_en = 1'b0;
    logic [CODE_W-1:0]  derate_code = 12'd0;
    logic               ramp_up = 1'b0;
    logic               ramp_down = 1'b0;
    logic               mute = 1'b0;
    logic [CODE_W-1:0]  amp_code;
    logic               ramp_done;
    logic               ramping;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    env_ramp_gen #(
        .CODE_W (CODE_W),
        .SLOPE_W(SLOPE_W),
        .DIV_W  (DIV_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .setpoint   (setpoint),
        .slope      (slope),
        .soft_start (soft_start),
        .max_code   (max_code),
        .step_div   (step_div),
        .derate_en  (derate_en),
        .derate_code(derate_code),
        .ramp_up    (ramp_up),
        .ramp_down  (ramp_down),
        .mute       (mute),
        .amp_code   (amp_code),
        .ramp_done  (ramp_done),
        .ramping    (ramping)
    );

    // Reference model state: 0 idle, 1 rise, 2 hold, 3 fall.
    int m_state = 0;
    int m_amp = 0;
    int m_done = 0;
    int m_cnt = 0;
    int m_sp = 0;

    function automatic int eff_of(int raw);
        int e = raw;
        if (e > int'(max_code)) e = int'(max_code);
        if (derate_en && e > int'(derate_code)) e = int'(derate_code);
        return e;
    endfunction

    function automatic int model_eff();
        return eff_of((m_state == 0) ? int'(setpoint) : m_sp);
    endfunction

    function automatic int approach(int a, int e, int s);
        if (a < e) return (a + s > e) ? e : a + s;
        if (a > e) return (a - e > s) ? a - s : e;
        return a;
    endfunction

    // Advance the model at each clock edge from the inputs held across it.
    always @(posedge clk) begin
        int eff, ss, nxt, n_state, n_amp, n_done;
        bit tk;
        if (!rst_n) begin
            m_state <= 0; m_amp <= 0; m_done <= 0; m_cnt <= 0; m_sp <= 0;
        end else begin
            eff = model_eff();
            ss = (int'(soft_start) < eff) ? int'(soft_start) : eff;
            tk = (m_state != 0) && (m_cnt >= int'(step_div));
            n_state = m_state; n_amp = m_amp; n_done = 0;
            if (mute) begin
                n_state = 0; n_amp = 0;
            end else if (m_state == 0) begin
                if (ramp_up && !ramp_down) begin
                    n_amp = ss;
                    if (ss == eff) begin n_state = 2; n_done = 1; end
                    else n_state = 1;
                end
            end else if (m_state == 3) begin
                if (ramp_up && !ramp_down) n_state = 1;
                else if (tk) begin
                    nxt = (m_amp > int'(slope)) ? m_amp - int'(slope) : 0;
                    n_amp = nxt;
                    if (nxt == 0) begin n_state = 0; n_done = 1; end
                end
            end else begin
                if (ramp_down) n_state = 3;
                else if (tk) begin
                    nxt = approach(m_amp, eff, int'(slope));
                    n_amp = nxt;
                    if (m_state == 1 && nxt == eff) begin n_state = 2; n_done = 1; end
                end
            end
            if (m_state == 0) m_sp <= int'(setpoint);
            m_cnt   <= (m_state == 0 || mute) ? 0 : (tk ? 0 : m_cnt + 1);
            m_state <= n_state;
            m_amp   <= n_amp;
            m_done  <= n_done;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the edge, against the model.
    always @(negedge clk) begin
        int e_amp, e_done, e_rmp;
        #1;
        if (mon_on && !finished) begin
            e_amp  = mute ? 0 : m_amp;
            e_done = (m_done != 0 && !mute) ? 1 : 0;
            e_rmp  = (!mute && (m_state == 1 || m_state == 3 ||
                      (m_state == 2 && m_amp != model_eff()))) ? 1 : 0;
            check("R1 model amp_code", int'(amp_code), e_amp);
            check("R7 model ramp_done", int'(ramp_done), e_done);
            check("R11 model ramping", int'(ramping), e_rmp);
            checks++;
            if (amp_code > max_code) begin
                errors++;
                $display("FAIL R5 amp above max act=%0d exp<=%0d", amp_code, max_code);
            end
        end
    end

    task automatic tick_n(int n);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic pulse_up();
        ramp_up = 1'b1; tick_n(1); ramp_up = 1'b0;
    endtask

    task automatic pulse_down();
        ramp_down = 1'b1; tick_n(1); ramp_down = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (cyc < 400) begin
            tick_n(1);
            cyc++;
            if (ramp_done) break;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    initial begin
        int cyc;
        tick_n(4);
        rst_n = 1'b1;
        tick_n(1);
        mon_on = 1'b1;
        // R3: reset state
        check("R3 reset amp_code", int'(amp_code), 0);
        check("R3 reset ramping", int'(ramping), 0);
        check("R3 reset ramp_done", int'(ramp_done), 0);

        // R2, R1, R7, R11: first burst to 256
        pulse_up();
        check("R2 soft start code", int'(amp_code), 64);
        check("R11 ramping in rise", int'(ramping), 1);
        wait_done(cyc);
        check("R1 rise step count", cyc, 12);
        check("R1 hold level", int'(amp_code), 256);
        tick_n(1);
        check("R7 done one cycle", int'(ramp_done), 0);

        // R4: setpoint change during a burst is ignored
        setpoint = 12'd1000;
        tick_n(5);
        check("R4 setpoint ignored in burst", int'(amp_code), 256);
        max_code = 12'd512;
        pulse_down();
        check("R8 no step on command edge", int'(amp_code), 256);
        wait_done(cyc);
        check("R7 fall step count", cyc, 16);
        check("R7 fall ends at zero", int'(amp_code), 0);
        check("R11 idle not ramping", int'(ramping), 0);

        // R5: captured 1000 clamped to 512
        pulse_up();
        check("R2 soft start second burst", int'(amp_code), 64);
        wait_done(cyc);
        check("R5 clamp to max_code", int'(amp_code), 512);

        // R6: derate slews down, then back up
        derate_en = 1'b1; derate_code = 12'd200;
        tick_n(1);
        check("R6 derate first step", int'(amp_code), 496);
        check("R11 ramping in hold slew", int'(ramping), 1);
        tick_n(25);
        check("R6 derate settled", int'(amp_code), 200);
        derate_en = 1'b0;
        tick_n(25);
        check("R6 derate released", int'(amp_code), 512);

        // R8: reversal during fall
        pulse_down();
        tick_n(3);
        check("R8 fall progress", int'(amp_code), 464);
        pulse_up();
        check("R8 reversal keeps code", int'(amp_code), 464);
        tick_n(1);
        check("R8 rises after reversal", int'(amp_code), 480);
        wait_done(cyc);
        check("R8 back at target", int'(amp_code), 512);

        // R9: prescaler of 3 gives a step every 4 cycles
        pulse_down();
        wait_done(cyc);
        step_div = 8'd3;
        pulse_up();
        check("R9 start code", int'(amp_code), 64);
        tick_n(3);
        check("R9 held between ticks", int'(amp_code), 64);
        tick_n(1);
        check("R9 first step", int'(amp_code), 80);
        tick_n(4);
        check("R9 second step", int'(amp_code), 96);
        wait_done(cyc);
        check("R9 slow rise reaches target", int'(amp_code), 512);
        step_div = 8'd0;

        // R3: mute mid-rise, and mute beating a ramp-up
        pulse_down();
        wait_done(cyc);
        pulse_up();
        tick_n(4);
        check("R3 pre-mute code", int'(amp_code), 128);
        mute = 1'b1;
        #1;
        check("R3 mute same cycle", int'(amp_code), 0);
        check("R3 mute clears ramping", int'(ramping), 0);
        tick_n(2);
        check("R3 muted code", int'(amp_code), 0);
        mute = 1'b0;
        tick_n(3);
        check("R3 idle after mute", int'(amp_code), 0);
        check("R3 idle flag after mute", int'(ramping), 0);
        mute = 1'b1; ramp_up = 1'b1;
        tick_n(2);
        check("R3 mute beats ramp_up", int'(amp_code), 0);
        ramp_up = 1'b0; mute = 1'b0;
        tick_n(1);
        check("R3 still idle", int'(amp_code), 0);

        // R10: both commands at once
        ramp_up = 1'b1; ramp_down = 1'b1;
        tick_n(1);
        ramp_up = 1'b0; ramp_down = 1'b0;
        tick_n(1);
        check("R10 both in idle ignored", int'(amp_code), 0);
        pulse_up();
        wait_done(cyc);
        ramp_up = 1'b1; ramp_down = 1'b1;
        tick_n(1);
        ramp_up = 1'b0; ramp_down = 1'b0;
        check("R10 command edge holds", int'(amp_code), 512);
        tick_n(1);
        check("R10 down wins", int'(amp_code), 496);
        wait_done(cyc);

        // R2, R7, R4: setpoint below soft start
        setpoint = 12'd40;
        tick_n(1);
        pulse_up();
        check("R2 start clamped to target", int'(amp_code), 40);
        check("R7 immediate done", int'(ramp_done), 1);
        setpoint = 12'd300;
        tick_n(10);
        check("R4 hold unchanged", int'(amp_code), 40);

        tick_n(2);
        summary();
    end

endmodule